// File: doc/BRIEF.md
# Halt-Mode Clock Power Sequencer

This controller moves a device into its deepest power-saving halt state and brings it back. When the processor signals a halt, the system clock keeps running for a flush interval. This lets pipelines and pending accesses drain. The length of that interval depends on the clock divider setting. After the flush, the sequencer gates off the system, core and peripheral clocks and disables the PLL. The oscillator is also stopped, but only when it runs from a crystal or resonator. An external clock input is left running.

Recovery starts when the active-low wake pin falls. The falling edge is caught by a flop that needs no clock, and that flop switches the oscillator back on at once. The event is then brought into the oscillator domain through a two-stage synchroniser. The sequencer waits until the oscillator reports that it is stable. It then runs a fixed PLL lock count and re-enables every clock. When the clocks return, it raises a single-cycle wake interrupt request.

A wake edge that arrives within the first few oscillator cycles after the halt state is entered is discarded. The current state is visible on a status output.

Top module: `halt_clk_sequencer`

## Requirements
- R1: While reset is asserted, and afterwards until a halt request arrives, the state is RUN. In that state `sysclk_en`, `core_clk_en`, `periph_clk_en`, `pll_en` and `osc_en` are all 1 and `wake_irq` is 0.
- R2: A halt request sampled in RUN starts FLUSH. FLUSH lasts FLUSH_BASE cycles (16 by default) for `div_sel` 2'b00 or 2'b01, twice that for 2'b10 and four times that for 2'b11. All five enables stay at 1 throughout FLUSH.
- R3: In HALTED, `sysclk_en`, `core_clk_en`, `periph_clk_en` and `pll_en` are all 0.
- R4: In HALTED, `osc_en` is 0 when `xtal_src` is 1 and no accepted wake edge has yet been seen. When `xtal_src` is 0, `osc_en` is 1 in every state.
- R5: A falling edge on `wake_n` after the guard interval drives `osc_en` to 1 with no clock edge needed. The state then moves to OSC_WAIT within a few cycles.
- R6: A falling edge on `wake_n` during the first WAKE_GUARD cycles (4 by default) of HALTED is discarded. The state stays HALTED and `osc_en` stays as it was.
- R7: OSC_WAIT holds until `osc_stable` is 1, with only `osc_en` on. PLL_LOCK follows, with `pll_en` and `osc_en` on and the other clocks still gated, and it lasts exactly LOCK_CYCLES cycles.
- R8: The PLL lock count is the same whatever the `xtal_src` setting and whatever the divider setting.
- R9: RESUME lasts one cycle with all enables at 1. `wake_irq` is 1 in that cycle only, and the state then returns to RUN.
- R10: `seq_state` encodes RUN=0, FLUSH=1, HALTED=2, OSC_WAIT=3, PLL_LOCK=4, RESUME=5.
- R11: Falling edges on `wake_n` in any state other than HALTED have no effect. In RUN, the state and all enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_req | input | 1 | Halt request from the processor idle instruction |
| div_sel | input | 2 | Clock divider select; sets the flush length |
| xtal_src | input | 1 | 1 = crystal/resonator source, 0 = external clock input |
| wake_n | input | 1 | Active-low wake pin; falling edge captured without a clock |
| osc_stable | input | 1 | Oscillator reports stable operation |
| sysclk_en | output | 1 | System clock output enable |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| wake_irq | output | 1 | Single-cycle wake interrupt request |
| seq_state | output | 3 | Current sequencer state code |

## Verification
Each divider code is exercised, and a scoreboard compares the measured FLUSH, PLL_LOCK and RESUME lengths with the expected values. A sequencer that decoded the divider wrongly, or that counted one cycle too many or too few, would show up as a length mismatch. A wake pulse is placed inside the guard window. A design that armed the wake capture too early would leave HALTED or restart the oscillator there. The instant `osc_en` rises is sampled one time unit after the wake edge, before the next clock edge, so a design that only reacted after the synchroniser would fail that check. Runs with an external clock source check that the oscillator is never switched off and that the lock count still runs in full. A wake edge given in RUN must leave the state and every enable unchanged.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_FLUSH    = 3'd1,
    ST_HALTED   = 3'd2,
    ST_OSC_WAIT = 3'd3,
    ST_PLL_LOCK = 3'd4,
    ST_RESUME   = 3'd5
  } hseq_state_e;

  typedef struct packed {
    logic sys;
    logic core;
    logic periph;
    logic pll;
    logic osc;
  } clk_gate_t;

  localparam clk_gate_t GATE_ALL_ON = '{sys: 1'b1, core: 1'b1, periph: 1'b1, pll: 1'b1, osc: 1'b1};

endpackage

// File: rtl/halt_rst_sync.sv
module halt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/halt_wake_capture.sv
module halt_wake_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_n,
  input  logic arm,
  output logic wake_flag,
  output logic wake_seen
);

  logic                   flag_q;
  logic [SYNC_STAGES-1:0] sync_q;

  // Clockless capture: the pin edge itself sets the flag, a low arm clears it.
  always_ff @(negedge wake_n or negedge arm) begin
    if (!arm) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], flag_q};
    end
  end

  assign wake_flag = flag_q;
  assign wake_seen = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/halt_flush_len.sv
module halt_flush_len #(
  parameter int FLUSH_BASE = 16,
  parameter int CNT_W      = 8
) (
  input  logic [1:0]       div_sel,
  output logic [CNT_W-1:0] flush_len
);

  always_comb begin
    unique case (div_sel)
      2'b10:   flush_len = CNT_W'(2 * FLUSH_BASE);
      2'b11:   flush_len = CNT_W'(4 * FLUSH_BASE);
      default: flush_len = CNT_W'(FLUSH_BASE);
    endcase
  end

endmodule

// File: rtl/halt_clk_sequencer.sv
module halt_clk_sequencer
  import halt_seq_pkg::*;
#(
  parameter int FLUSH_BASE  = 16,
  parameter int LOCK_CYCLES = 131072,
  parameter int WAKE_GUARD  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic [1:0] div_sel,
  input  logic       xtal_src,
  input  logic       wake_n,
  input  logic       osc_stable,
  output logic       sysclk_en,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       pll_en,
  output logic       osc_en,
  output logic       wake_irq,
  output logic [2:0] seq_state
);

  localparam int MAX_FLUSH = 4 * FLUSH_BASE;
  localparam int MAX_COUNT = (MAX_FLUSH > LOCK_CYCLES) ? MAX_FLUSH : LOCK_CYCLES;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);
  localparam int GRD_W     = $clog2(WAKE_GUARD + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [GRD_W-1:0] GRD_LAST  = GRD_W'(WAKE_GUARD - 1);
  localparam logic [GRD_W-1:0] GRD_FULL  = GRD_W'(WAKE_GUARD);

  logic              srst_n;
  hseq_state_e       state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CNT_W-1:0]  flen_q, flen_n;
  logic [CNT_W-1:0]  flen_dec;
  logic [GRD_W-1:0]  gcnt_q, gcnt_n;
  logic              armed_q, armed_n;
  logic              wake_flag, wake_seen;
  clk_gate_t         gate;

  halt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  halt_flush_len #(.FLUSH_BASE(FLUSH_BASE), .CNT_W(CNT_W)) u_flen (
    .div_sel   (div_sel),
    .flush_len (flen_dec)
  );

  halt_wake_capture #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk       (clk),
    .rst_n     (srst_n),
    .wake_n    (wake_n),
    .arm       (armed_q),
    .wake_flag (wake_flag),
    .wake_seen (wake_seen)
  );

  // Next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    flen_n  = flen_q;
    gcnt_n  = gcnt_q;
    armed_n = armed_q;
    unique case (state_q)
      ST_RUN: begin
        cnt_n = '0;
        if (halt_req) begin
          state_n = ST_FLUSH;
          flen_n  = flen_dec;
        end
      end
      ST_FLUSH: begin
        if (cnt_q == flen_q - CNT_W'(1)) begin
          state_n = ST_HALTED;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      ST_HALTED: begin
        if (gcnt_q != GRD_FULL) gcnt_n = gcnt_q + GRD_W'(1);
        armed_n = armed_q || (gcnt_q >= GRD_LAST);
        if (armed_q && wake_seen) state_n = ST_OSC_WAIT;
      end
      ST_OSC_WAIT: begin
        cnt_n = '0;
        if (osc_stable) state_n = ST_PLL_LOCK;
      end
      ST_PLL_LOCK: begin
        if (cnt_q == LOCK_LAST) begin
          state_n = ST_RESUME;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      ST_RESUME: state_n = ST_RUN;
      default:   state_n = ST_RUN;
    endcase
    if (state_n != ST_HALTED) begin
      gcnt_n  = '0;
      armed_n = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      flen_q  <= CNT_W'(FLUSH_BASE);
      gcnt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      gcnt_q  <= gcnt_n;
      armed_q <= armed_n;
      if (state_q == ST_RUN) flen_q <= flen_n;
    end
  end

  // Output decode
  always_comb begin
    gate = GATE_ALL_ON;
    unique case (state_q)
      ST_HALTED: begin
        gate     = '0;
        gate.osc = !xtal_src || wake_flag;
      end
      ST_OSC_WAIT: begin
        gate     = '0;
        gate.osc = 1'b1;
      end
      ST_PLL_LOCK: begin
        gate     = '0;
        gate.osc = 1'b1;
        gate.pll = 1'b1;
      end
      default: gate = GATE_ALL_ON;
    endcase
  end

  assign sysclk_en     = gate.sys;
  assign core_clk_en   = gate.core;
  assign periph_clk_en = gate.periph;
  assign pll_en        = gate.pll;
  assign osc_en        = gate.osc;
  assign wake_irq      = (state_q == ST_RESUME);
  assign seq_state     = state_q;

endmodule

// File: rtl/halt_seq_checker.sv
module halt_seq_checker
  import halt_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       xtal_src,
  input logic       osc_stable,
  input logic       sysclk_en,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       pll_en,
  input logic       osc_en,
  input logic       wake_irq,
  input logic [2:0] seq_state
);

  p_run_all_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_RUN) |-> (sysclk_en && core_clk_en && periph_clk_en && pll_en && osc_en && !wake_irq));

  p_flush_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_FLUSH) |-> (sysclk_en && core_clk_en && periph_clk_en));

  p_halted_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_HALTED) |-> (!sysclk_en && !core_clk_en && !periph_clk_en && !pll_en));

  p_ext_osc_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_src |-> osc_en);

  p_wait_from_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_state == ST_OSC_WAIT) |-> ($past(seq_state) == ST_HALTED));

  p_hold_unstable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_OSC_WAIT && !osc_stable) |=> (seq_state == ST_OSC_WAIT));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  p_resume_then_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_RESUME) |=> (seq_state == ST_RUN));

  p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 3'd5);

endmodule

bind halt_clk_sequencer halt_seq_checker u_halt_seq_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .xtal_src      (xtal_src),
  .osc_stable    (osc_stable),
  .sysclk_en     (sysclk_en),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .pll_en        (pll_en),
  .osc_en        (osc_en),
  .wake_irq      (wake_irq),
  .seq_state     (seq_state)
);

// File: tb/test_halt_clk_sequencer.sv
module test_halt_clk_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int FBASE      = 16;
  localparam int LOCKN      = 40;
  localparam logic [2:0] S_RUN = 3'd0, S_FLUSH = 3'd1, S_HALTED = 3'd2,
                         S_OWAIT = 3'd3, S_LOCK = 3'd4, S_RESUME = 3'd5;

  typedef struct {
    logic [2:0] st;
    int         len;
    string      req;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n, halt_req, xtal_src, wake_n, osc_stable;
  logic [1:0] div_sel;
  logic       sysclk_en, core_clk_en, periph_clk_en, pll_en, osc_en, wake_irq;
  logic [2:0] seq_state;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;
  int irq_exp = 0;
  bit mon_on = 1'b0;
  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_clk_sequencer #(.FLUSH_BASE(FBASE), .LOCK_CYCLES(LOCKN)) i_halt_clk_sequencer (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .div_sel(div_sel),
    .xtal_src(xtal_src), .wake_n(wake_n), .osc_stable(osc_stable),
    .sysclk_en(sysclk_en), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .pll_en(pll_en), .osc_en(osc_en), .wake_irq(wake_irq), .seq_state(seq_state)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] enables();
    return {sysclk_en, core_clk_en, periph_clk_en, pll_en, osc_en};
  endfunction

  task automatic wait_state(input logic [2:0] s, input int maxc, input string req);
    int i;
    for (i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (seq_state == s) break;
    end
    check(seq_state == s, req, seq_state, s);
  endtask

  // Scoreboard monitor: measures state dwell times and compares against queue
  always @(negedge clk) begin : monitor
    static logic [2:0] prev = 3'd0;
    static int run = 0;
    if (mon_on) begin
      if (wake_irq) begin
        irq_seen++;
        check(seq_state == S_RESUME, "R9 irq outside RESUME", seq_state, S_RESUME);
      end
      if (seq_state == prev) begin
        run++;
      end else begin
        if (prev == S_FLUSH || prev == S_LOCK || prev == S_RESUME) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "scoreboard empty", prev, 0);
          end else begin
            exp_item_t e;
            e = sb_q.pop_front();
            check(e.st == prev && e.len == run, e.req, run, e.len);
          end
        end
        prev = seq_state;
        run  = 1;
      end
    end else begin
      prev = seq_state;
      run  = 1;
    end
  end

  // Driver: one full halt/wake round with expected dwell times pushed first
  task automatic halt_round(input logic [1:0] dsel, input logic xt, input bit early_wake);
    int flen;
    flen = (dsel == 2'b11) ? 4*FBASE : (dsel == 2'b10) ? 2*FBASE : FBASE;
    sb_q.push_back('{S_FLUSH, flen, "R2 flush length"});
    sb_q.push_back('{S_LOCK, LOCKN, "R7 R8 lock length"});
    sb_q.push_back('{S_RESUME, 1, "R9 resume length"});
    irq_exp++;
    div_sel  = dsel;
    xtal_src = xt;
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    check(seq_state == S_FLUSH, "R2 R10 enter FLUSH", seq_state, S_FLUSH);
    check(enables() == 5'b11111, "R2 enables in FLUSH", enables(), 5'b11111);
    wait_state(S_HALTED, 4*FBASE + 4, "R2 reach HALTED");
    check({sysclk_en, core_clk_en, periph_clk_en, pll_en} == 4'b0000, "R3 gated in HALTED",
          {sysclk_en, core_clk_en, periph_clk_en, pll_en}, 0);
    check(osc_en == !xt, "R4 osc in HALTED", osc_en, !xt);
    if (early_wake) begin
      #(CLK_PERIOD/4) wake_n = 1'b0;
      #(CLK_PERIOD/4) wake_n = 1'b1;
      repeat (8) @(negedge clk);
      check(seq_state == S_HALTED, "R6 early wake ignored (state)", seq_state, S_HALTED);
      check(osc_en == !xt, "R6 early wake ignored (osc)", osc_en, !xt);
    end else begin
      repeat (6) @(negedge clk);
    end
    #(CLK_PERIOD/4) wake_n = 1'b0;
    #1;
    check(osc_en == 1'b1, "R5 osc on from wake edge", osc_en, 1);
    wait_state(S_OWAIT, 6, "R5 reach OSC_WAIT");
    wake_n = 1'b1;
    repeat (3) @(negedge clk);
    check(seq_state == S_OWAIT, "R7 hold for osc_stable", seq_state, S_OWAIT);
    check(enables() == 5'b00001, "R7 enables in OSC_WAIT", enables(), 5'b00001);
    osc_stable = 1'b1;
    wait_state(S_LOCK, 3, "R7 reach PLL_LOCK");
    check(enables() == 5'b00011, "R7 enables in PLL_LOCK", enables(), 5'b00011);
    wait_state(S_RESUME, LOCKN + 4, "R9 reach RESUME");
    check(enables() == 5'b11111 && wake_irq, "R9 resume outputs", {enables(), wake_irq}, 6'b111111);
    osc_stable = 1'b0;
    wait_state(S_RUN, 3, "R9 back to RUN");
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; halt_req = 1'b0; div_sel = 2'b00; xtal_src = 1'b1;
    wake_n = 1'b1; osc_stable = 1'b0;
    repeat (3) @(negedge clk);
    check(seq_state == S_RUN, "R1 R10 reset state", seq_state, S_RUN);
    check(enables() == 5'b11111 && !wake_irq, "R1 reset outputs", {enables(), wake_irq}, 6'b111110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    check(seq_state == S_RUN && enables() == 5'b11111, "R1 idle after reset", seq_state, S_RUN);

    // R11: wake edge in RUN has no effect
    #(CLK_PERIOD/4) wake_n = 1'b0;
    #(CLK_PERIOD/4) wake_n = 1'b1;
    repeat (5) @(negedge clk);
    check(seq_state == S_RUN, "R11 wake in RUN ignored (state)", seq_state, S_RUN);
    check(enables() == 5'b11111, "R11 wake in RUN ignored (enables)", enables(), 5'b11111);

    halt_round(2'b00, 1'b1, 1'b1);
    halt_round(2'b01, 1'b1, 1'b0);
    halt_round(2'b10, 1'b0, 1'b1);
    halt_round(2'b11, 1'b1, 1'b0);
    halt_round(2'b11, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 R7 R9 scoreboard drained", sb_q.size(), 0);
    check(irq_seen == irq_exp, "R9 wake irq count", irq_seen, irq_exp);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule